// File: doc/BRIEF.md
# Exponent-Aligned Wide Fixed-Point Accumulator

This block sums a stream of single-precision style floating-point values without the loss that occurs when a small value is added to a large floating-point total. Each incoming value is shifted, according to its exponent, onto a wide two's-complement fixed-point grid. The position of the binary point on that grid is fixed by a parameter. The aligned value is then added into a wide running sum. Only the incoming value passes through the shifter, and that shifter can be pipelined to any depth. The feedback path is a plain integer adder.

The raw fixed-point sum is always visible on an output port. A separate normaliser, which a caller triggers only when it wants a floating-point result, converts the sum to sign/magnitude form. It finds the leading one, derives the exponent from where that one sits relative to the binary point, and truncates the fraction.

Special floating-point values are not handled. A value too large for the grid only raises a sticky flag.

Top module: `wide_fp_accum`

## Requirements
- R1: After reset, `acc_sum` is 0 and `acc_ovf` and `res_valid` are low. A cycle with `clear` high sets `acc_sum` to 0, drops `acc_ovf`, and discards every summand still in the alignment pipeline as well as any summand offered in that same cycle.
- R2: A summand with sign s, exponent field e (nonzero) and 23-bit fraction f is added as (-1)^s times the magnitude floor((1 + f/2^23) * 2^(e-127) * 2^FRAC_POS). The result wraps modulo 2^ACC_W. A summand taken at clock edge k shows in `acc_sum` after edge k+ALIGN_LAT.
- R3: A summand whose exponent field is 0 adds nothing to the sum, whatever its sign and fraction.
- R4: Aligned bits that fall below the least significant accumulator bit are dropped, which rounds the magnitude toward zero. A summand lying wholly below that bit adds 0.
- R5: A summand with e - 127 + FRAC_POS >= ACC_W-1 adds nothing to the sum and sets `acc_ovf`. The flag stays high until the next clear or reset.
- R6: Back-to-back valid cycles each add exactly one summand. Cycles with `in_valid` low leave the sum unchanged.
- R7: A `norm_req` at edge k makes `res_valid` high for exactly the cycle after edge k. The result fields are computed from the sum held just before edge k, as follows:
  - `res_sign` is the top bit of that sum.
  - With p as the bit position of the leading one of the magnitude, `res_exp` is p - FRAC_POS + 127.
  - `res_man` is the 23 bits directly below that leading one, truncated and zero-filled on the right.
- R8: Normalising a zero sum gives sign 0, exponent 0 and fraction 0.
- R9: A negative sum is normalised from its two's-complement magnitude. The most negative value gives p = ACC_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Zero the sum and flag, flush in-flight summands |
| in_valid | input | 1 | Summand offered this cycle |
| in_sign | input | 1 | Summand sign |
| in_exp | input | 8 | Summand biased exponent |
| in_man | input | 23 | Summand fraction (hidden one implied) |
| norm_req | input | 1 | Request a normalised copy of the current sum |
| acc_sum | output | ACC_W | Raw two's-complement fixed-point sum |
| acc_ovf | output | 1 | Sticky out-of-range summand flag |
| res_valid | output | 1 | Normalised result valid |
| res_sign | output | 1 | Result sign |
| res_exp | output | 8 | Result biased exponent |
| res_man | output | 23 | Result fraction |

## Verification
The bench builds the block with ACC_W = 64, FRAC_POS = 32 and ALIGN_LAT = 2. The two-stage aligner means a clear can land while summands are still in flight, so the flush behaviour is exercised. With 32 fractional bits, the range of exponents around 90 to 118 covers both partial truncation and complete loss below the grid. An exponent of 158 is the first value the 64-bit grid cannot hold. Sums of large summands reach the negative half and the wrap region, which exercises the normaliser's magnitude path.

// File: rtl/fxacc_pkg.sv
package fxacc_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int BIAS  = 127;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fp_word_t;
endpackage

// File: rtl/fxacc_align.sv
module fxacc_align import fxacc_pkg::*; #(
  parameter int ACC_W    = 64,
  parameter int FRAC_POS = 32,
  parameter int LAT      = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             in_valid,
  input  fp_word_t         in_word,
  output logic             a_valid,
  output logic [ACC_W-1:0] a_val,
  output logic             a_ovf
);
  // Shift that places the hidden-one significand onto the fixed-point grid
  localparam int SH_OFS = FRAC_POS - BIAS - MAN_W;
  localparam int SH_MAX = ACC_W - 1 - MAN_W;

  typedef struct packed {
    logic [ACC_W-1:0] val;
    logic             ovf;
  } aligned_t;

  function automatic aligned_t align_word(fp_word_t w);
    aligned_t         r;
    logic [ACC_W-1:0] mag;
    int               sh;
    r   = '0;
    mag = '0;
    mag[MAN_W:0] = {1'b1, w.man};
    sh  = int'(w.exp) + SH_OFS;
    if (w.exp == '0) begin
      mag = '0;
    end else if (sh >= SH_MAX) begin
      r.ovf = 1'b1;
      mag   = '0;
    end else if (sh >= 0) begin
      mag = mag << sh;
    end else if (sh > -(MAN_W + 1)) begin
      mag = mag >> (-sh);
    end else begin
      mag = '0;
    end
    r.val = w.sign ? (~mag + 1'b1) : mag;
    return r;
  endfunction

  logic     v_q [LAT];
  aligned_t d_q [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
          v_q[0] <= 1'b0;
          d_q[0] <= '0;
        end else begin
          v_q[0] <= in_valid;
          d_q[0] <= align_word(in_word);
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
          v_q[i] <= 1'b0;
          d_q[i] <= '0;
        end else begin
          v_q[i] <= v_q[i-1];
          d_q[i] <= d_q[i-1];
        end
      end
    end
  end

  assign a_valid = v_q[LAT-1];
  assign a_val   = d_q[LAT-1].val;
  assign a_ovf   = d_q[LAT-1].ovf;

  // R1
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !a_valid);
endmodule

// File: rtl/fxacc_loop.sv
module fxacc_loop #(
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             a_valid,
  input  logic [ACC_W-1:0] a_val,
  input  logic             a_ovf,
  output logic [ACC_W-1:0] sum_q,
  output logic             ovf_q
);
  logic take_add;
  logic take_ovf;
  assign take_add = a_valid && !a_ovf && !clear;
  assign take_ovf = a_valid &&  a_ovf && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (take_add) sum_q <= sum_q + a_val;
      if (take_ovf) ovf_q <= 1'b1;
    end
  end

  // R1
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sum_q == '0) && !ovf_q);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_valid && !clear) |=> $stable(sum_q));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clear) |=> ovf_q);
  // R5
  ovf_no_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ovf |=> $stable(sum_q) && ovf_q);
endmodule

// File: rtl/fxacc_norm.sv
module fxacc_norm import fxacc_pkg::*; #(
  parameter int ACC_W    = 64,
  parameter int FRAC_POS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [ACC_W-1:0] sum,
  output logic             res_valid,
  output fp_word_t         res
);
  localparam int PW = $clog2(ACC_W);

  function automatic logic [PW-1:0] lead_pos(logic [ACC_W-1:0] v);
    logic [PW-1:0] p;
    p = '0;
    for (int i = 0; i < ACC_W; i++)
      if (v[i]) p = PW'(i);
    return p;
  endfunction

  function automatic fp_word_t normalise(logic [ACC_W-1:0] s);
    fp_word_t         r;
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] tmp;
    int               p;
    r   = '0;
    mag = s[ACC_W-1] ? (~s + 1'b1) : s;
    if (mag != '0) begin
      p = int'(lead_pos(mag));
      if (p >= MAN_W) tmp = mag >> (p - MAN_W);
      else            tmp = mag << (MAN_W - p);
      r.sign = s[ACC_W-1];
      r.exp  = EXP_W'(p - FRAC_POS + BIAS);
      r.man  = tmp[MAN_W-1:0];
    end
    return r;
  endfunction

  logic sum_is_zero;
  assign sum_is_zero = (sum == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= req;
      if (req) res <= normalise(sum);
    end
  end

  // R7
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> res_valid);
  // R7
  no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !res_valid);
  // R9
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> res.sign == $past(sum[ACC_W-1]));
  // R8
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sum_is_zero) |=> (res == '0));
endmodule

// File: rtl/wide_fp_accum.sv
module wide_fp_accum import fxacc_pkg::*; #(
  parameter int ACC_W     = 64,
  parameter int FRAC_POS  = 32,
  parameter int ALIGN_LAT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             in_valid,
  input  logic             in_sign,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [MAN_W-1:0] in_man,
  input  logic             norm_req,
  output logic [ACC_W-1:0] acc_sum,
  output logic             acc_ovf,
  output logic             res_valid,
  output logic             res_sign,
  output logic [EXP_W-1:0] res_exp,
  output logic [MAN_W-1:0] res_man
);
  fp_word_t         in_word;
  fp_word_t         res_word;
  logic             a_valid;
  logic [ACC_W-1:0] a_val;
  logic             a_ovf;

  assign in_word = '{sign: in_sign, exp: in_exp, man: in_man};

  fxacc_align #(.ACC_W(ACC_W), .FRAC_POS(FRAC_POS), .LAT(ALIGN_LAT)) u_align (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .in_word(in_word),
    .a_valid(a_valid), .a_val(a_val), .a_ovf(a_ovf)
  );

  fxacc_loop #(.ACC_W(ACC_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .clear(clear), .a_valid(a_valid), .a_val(a_val),
    .a_ovf(a_ovf), .sum_q(acc_sum), .ovf_q(acc_ovf)
  );

  fxacc_norm #(.ACC_W(ACC_W), .FRAC_POS(FRAC_POS)) u_norm (
    .clk(clk), .rst_n(rst_n), .req(norm_req), .sum(acc_sum),
    .res_valid(res_valid), .res(res_word)
  );

  assign res_sign = res_word.sign;
  assign res_exp  = res_word.exp;
  assign res_man  = res_word.man;
endmodule

// File: tb/wide_fp_accum_test.sv
module wide_fp_accum_test;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W      = 64;
  localparam int FRAC_POS   = 32;
  localparam int LAT        = 2;

  logic        clk = 1'b0;
  logic        rst_n, clear, in_valid, in_sign, norm_req;
  logic [7:0]  in_exp;
  logic [22:0] in_man;
  logic [63:0] acc_sum;
  logic        acc_ovf, res_valid, res_sign;
  logic [7:0]  res_exp;
  logic [22:0] res_man;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_fp_accum #(.ACC_W(ACC_W), .FRAC_POS(FRAC_POS), .ALIGN_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_man(in_man), .norm_req(norm_req), .acc_sum(acc_sum),
    .acc_ovf(acc_ovf), .res_valid(res_valid), .res_sign(res_sign),
    .res_exp(res_exp), .res_man(res_man)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";

  // Behavioural reference state
  longint m_sum;
  bit     m_ovf;
  bit     pv   [LAT];
  longint pval [LAT];
  bit     povf [LAT];
  bit     m_rv, m_rs;
  int     m_re, m_rm;

  task automatic check(bit ok, string req, string what, longint act, longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  // R2 R3 R4 R5: value scaled by 2^FRAC_POS, computed by repeated doubling/halving
  task automatic ref_align(input bit s, input int e, input int f,
                           output longint v, output bit o);
    int k;
    v = 0; o = 0;
    if (e == 0) return;
    if (e - 127 + FRAC_POS >= ACC_W - 1) begin o = 1; return; end
    v = 64'd8388608 + longint'(f);
    k = e - 150 + FRAC_POS;
    if (k >= 0) repeat (k) v = v * 2;
    else        repeat (-k) v = v / 2;
    if (s) v = -v;
  endtask

  always @(posedge clk) begin
    longint v; bit o; logic [63:0] mag; int p;
    if (!rst_n) begin
      m_sum = 0; m_ovf = 0; m_rv = 0; m_rs = 0; m_re = 0; m_rm = 0;
      for (int i = 0; i < LAT; i++) begin pv[i] = 0; pval[i] = 0; povf[i] = 0; end
    end else begin
      m_rv = norm_req;
      if (norm_req) begin
        mag = m_sum[63] ? -m_sum : m_sum;
        m_rs = 0; m_re = 0; m_rm = 0;
        if (mag != 0) begin
          p = 0;
          for (int i = 0; i < 64; i++) if (mag[i]) p = i;
          m_rs = m_sum[63];
          m_re = p - FRAC_POS + 127;
          if (p >= 23) m_rm = int'((mag >> (p - 23)) & 64'h7FFFFF);
          else         m_rm = int'((mag << (23 - p)) & 64'h7FFFFF);
        end
      end
      if (clear) begin
        m_sum = 0; m_ovf = 0;
        for (int i = 0; i < LAT; i++) pv[i] = 0;
      end else begin
        if (pv[LAT-1]) begin
          if (povf[LAT-1]) m_ovf = 1;
          else             m_sum = m_sum + pval[LAT-1];
        end
        for (int i = LAT - 1; i > 0; i--) begin
          pv[i] = pv[i-1]; pval[i] = pval[i-1]; povf[i] = povf[i-1];
        end
        ref_align(in_sign, int'(in_exp), int'(in_man), v, o);
        pv[0] = in_valid; pval[0] = v; povf[0] = o;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(acc_sum == m_sum, tag, "acc_sum", acc_sum, m_sum);
      check(acc_ovf == m_ovf, tag, "acc_ovf", longint'(acc_ovf), longint'(m_ovf));
      check(res_valid == m_rv, tag, "res_valid", longint'(res_valid), longint'(m_rv));
      if (m_rv) begin
        check(res_sign == m_rs, tag, "res_sign", longint'(res_sign), longint'(m_rs));
        check(int'(res_exp) == m_re, tag, "res_exp", longint'(res_exp), longint'(m_re));
        check(int'(res_man) == m_rm, tag, "res_man", longint'(res_man), longint'(m_rm));
      end
    end
  end

  task automatic send(bit s, int e, int f, string t);
    @(negedge clk);
    tag = t; in_valid = 1; in_sign = s; in_exp = 8'(e); in_man = 23'(f);
    clear = 0; norm_req = 0;
  endtask

  task automatic idle(int n, string t);
    tag = t;
    repeat (n) begin
      @(negedge clk);
      in_valid = 0; clear = 0; norm_req = 0;
    end
  endtask

  task automatic norm(string t);
    @(negedge clk);
    tag = t; in_valid = 0; clear = 0; norm_req = 1;
  endtask

  task automatic clr(string t);
    @(negedge clk);
    tag = t; in_valid = 0; norm_req = 0; clear = 1;
  endtask

  initial begin
    rst_n = 0; clear = 0; in_valid = 0; in_sign = 0; in_exp = 0; in_man = 0; norm_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3, "R1");                        // reset state
    check(acc_sum == 0 && !acc_ovf && !res_valid, "R1", "reset", acc_sum, 0);
    norm("R8"); idle(2, "R8");            // zero sum normalises to zero
    send(0, 127, 0, "R2");                // +1.0
    send(0, 127, 23'h400000, "R2");       // +1.5
    send(1, 125, 0, "R2");                // -0.25
    idle(4, "R2");
    check(acc_sum == 64'h0000_0002_4000_0000, "R2", "sum 2.25", acc_sum, 64'h2_4000_0000);
    norm("R7"); idle(2, "R7");
    send(1, 0, 23'h7FFFFF, "R3"); idle(4, "R3");   // zero exponent ignored
    send(0, 100, 23'h12345, "R4");                 // partly truncated
    send(1, 100, 1, "R4");                         // negative, truncated toward zero
    send(0, 90, 23'h7FFFFF, "R4");                 // wholly below grid
    idle(4, "R4"); norm("R7"); idle(2, "R7");
    send(0, 158, 0, "R5"); idle(4, "R5");          // out of range
    check(acc_ovf == 1, "R5", "ovf set", longint'(acc_ovf), 1);
    send(0, 120, 5, "R5"); idle(4, "R5");          // flag sticks, adds continue
    clr("R1"); idle(2, "R1");
    check(acc_sum == 0 && !acc_ovf, "R1", "after clear", acc_sum, 0);
    for (int i = 0; i < 40; i++)
      send(($urandom % 4) == 0, 100 + int'($urandom % 50), int'($urandom % 8388608), "R6");
    idle(4, "R6"); norm("R7"); idle(2, "R7");
    // clear with in-flight and same-cycle summands
    send(0, 140, 7, "R1");
    @(negedge clk); in_valid = 1; in_exp = 8'd141; clear = 1;
    idle(4, "R1");
    check(acc_sum == 0, "R1", "flush", acc_sum, 0);
    // negative sums and the most negative value
    send(1, 157, 0, "R9"); idle(4, "R9"); norm("R9"); idle(2, "R9");
    send(1, 157, 0, "R9"); idle(4, "R9");
    check(acc_sum == 64'h8000_0000_0000_0000, "R9", "min value", acc_sum, 64'h8000_0000_0000_0000);
    norm("R9"); idle(2, "R9");
    clr("R9"); send(1, 130, 23'h2AAAAA, "R9"); send(0, 110, 3, "R9");
    idle(4, "R9"); norm("R9"); idle(3, "R9");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule